// File: doc/BRIEF.md
# In-Place Descending RAM Sorter with Cycle Meter

This block owns a single-port memory of 8-bit words (256 words by default) and reorders its contents in place. Values are compared as unsigned numbers. When the block finishes, the largest value sits at address 0 and the contents never increase with rising address. A host first fills the memory through a plain read/write port. It then pulses `start`, waits for `done`, and reads the result back through the same port.

The sort is a bubble sort over adjacent pairs. Each pass is one word shorter than the one before it, and the sort stops early after any pass that exchanges nothing. Each pair costs three cycles (read, read, compare), plus two write cycles when the pair is exchanged. A 32-bit counter records how many cycles the block spent busy. A select input brings out either its low or its high 16 bits. The depth is set at elaboration through the address width (2^8 by default, up to 2^14).

Top module: `ram_sorter`

## Requirements
- R1: After reset, `busy` and `done` are 0 and the cycle count reads 0.
- R2: A `start` pulse sampled while idle makes `busy` 1 and `done` 0 on the next cycle, and clears the cycle count to 0 at that same edge.
- R3: When `done` rises, the memory contents never increase from address 0 upward, compared as unsigned 8-bit values.
- R4: When `done` rises, the memory holds exactly the multiset of values it held at start.
- R5: `done` stays 1, with `busy` 0, until the next accepted `start`. `busy` and `done` are never 1 together.
- R6: A `start` pulse while `busy` is 1 has no effect: the sort and the cycle count carry on unchanged.
- R7: While idle, the host port writes `host_wdata` at `host_addr` when `host_we` is 1. `host_rdata` returns the word at the address presented one clock earlier.
- R8: Host writes presented while `busy` is 1 are discarded and do not alter the memory.
- R9: The cycle count rises by 1 in every busy cycle and is frozen while idle. Its final value is 3 per compared pair plus 2 per exchange. Pass k (from 0) compares pairs 0..N-2-k. The sort ends after a pass with no exchange, or after the pass that compares only pair 0.
- R10: With `cnt_hi_sel` = 0, `cycle_half` shows count bits 15..0. With `cnt_hi_sel` = 1, it shows bits 31..16.
- R11: Input that is already in non-increasing order finishes after one pass, in exactly 3*(N-1) cycles.
- R12: The compare is unsigned: values 0x80 and above rank above 0x7F and below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sort (accepted only while idle) |
| busy | output | 1 | Sort in progress |
| done | output | 1 | Sort finished; held until next start |
| host_addr | input | ADDR_W | Host word address |
| host_we | input | 1 | Host write enable (ignored while busy) |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered read data, one cycle after address |
| cnt_hi_sel | input | 1 | 0: low half of cycle count, 1: high half |
| cycle_half | output | CNT_W/2 | Selected half of the cycle count |

## Verification
A wrong exchange decision or a wrong pair index appears after `done` as an out-of-order word or a changed multiset when the memory is read back. A wrong pass limit or a wrong early-exit decision does not corrupt data, but it changes the cycle count. The bench therefore compares the count against a model total per input pattern; one compare too many or too few shifts it by 3. A counter that fails to clear or to freeze shows at the port on the cycle after `start`, or within a few idle cycles after `done`.

// File: rtl/sort_pkg.sv
// Package: shared state encoding for the in-place sorter.
// Assumes: no other package defines these names.
package sort_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD_A = 3'd1,
        ST_RD_B = 3'd2,
        ST_CMP  = 3'd3,
        ST_WR_A = 3'd4,
        ST_WR_B = 3'd5
    } sort_state_e;
endpackage

// File: rtl/sort_ram.sv
// Module: single-port word memory with registered read.
// Assumes: one access per cycle; read data reflects the address of the
// previous cycle; content is undefined until written.
module sort_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store write data.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Register the read word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/sort_cycle_meter.sv
// Module: busy-cycle counter with half-word readout.
// Assumes: clear and inc never need to act together; clear wins.
module sort_cycle_meter #(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               inc,
    input  logic               hi_sel,
    output logic [CNT_W-1:0]   count,
    output logic [CNT_W/2-1:0] half
);
    localparam int HALF_W = CNT_W / 2;

    // Count busy cycles; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

    // Pick the requested half.
    always_comb begin
        half = hi_sel ? count[CNT_W-1:HALF_W] : count[HALF_W-1:0];
    end
endmodule

// File: rtl/sort_ctrl.sv
// Module: bubble-sort sequencer driving the memory during a sort.
// Assumes: memory read latency of one cycle; depth at least 2.
// Each pair costs read, read, compare, and two writes when exchanged.
module sort_ctrl #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr,
    output logic              we,
    output logic [DATA_W-1:0] wdata,
    output logic              busy,
    output logic              done,
    output logic              accept
);
    import sort_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] FIRST_LIM = ADDR_W'(DEPTH - 2);

    sort_state_e       state_q;
    logic [ADDR_W-1:0] idx_q;
    logic [ADDR_W-1:0] lim_q;
    logic              swapped_q;
    logic [DATA_W-1:0] a_q;
    logic [DATA_W-1:0] b_q;
    logic              step;
    logic              swap_seen;
    logic              pass_end;
    logic              finish;

    // Status and start acceptance.
    always_comb begin
        busy   = (state_q != ST_IDLE);
        accept = start && (state_q == ST_IDLE);
    end

    // Pair completion and end-of-sort decision.
    always_comb begin
        step      = ((state_q == ST_CMP) && !(a_q < rdata)) || (state_q == ST_WR_B);
        swap_seen = swapped_q || (state_q == ST_WR_B);
        pass_end  = step && (idx_q == lim_q);
        finish    = pass_end && (!swap_seen || (lim_q == '0));
    end

    // Memory address, enable and data for each state.
    always_comb begin
        addr  = idx_q;
        we    = 1'b0;
        wdata = b_q;
        unique case (state_q)
            ST_RD_B: addr = idx_q + 1'b1;
            ST_WR_A: begin
                we    = 1'b1;
                wdata = b_q;
            end
            ST_WR_B: begin
                addr  = idx_q + 1'b1;
                we    = 1'b1;
                wdata = a_q;
            end
            default: addr = idx_q;
        endcase
    end

    // Sequencer state, pass bookkeeping and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            lim_q     <= '0;
            swapped_q <= 1'b0;
            a_q       <= '0;
            b_q       <= '0;
            done      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        idx_q     <= '0;
                        lim_q     <= FIRST_LIM;
                        swapped_q <= 1'b0;
                        done      <= 1'b0;
                        state_q   <= ST_RD_A;
                    end
                end
                ST_RD_A: state_q <= ST_RD_B;
                ST_RD_B: begin
                    a_q     <= rdata;
                    state_q <= ST_CMP;
                end
                ST_CMP: begin
                    b_q <= rdata;
                    if (a_q < rdata) begin
                        state_q <= ST_WR_A;
                    end
                end
                ST_WR_A: state_q <= ST_WR_B;
                default: ;
            endcase
            if (step) begin
                if (finish) begin
                    state_q <= ST_IDLE;
                    done    <= 1'b1;
                end else if (pass_end) begin
                    idx_q     <= '0;
                    lim_q     <= lim_q - 1'b1;
                    swapped_q <= 1'b0;
                    state_q   <= ST_RD_A;
                end else begin
                    idx_q     <= idx_q + 1'b1;
                    swapped_q <= swap_seen;
                    state_q   <= ST_RD_A;
                end
            end
        end
    end
endmodule

// File: rtl/ram_sorter.sv
// Module: top level; memory, sequencer and cycle meter with host access.
// Assumes: the host waits for done before reading results; host writes
// while busy are dropped; host_rdata shows sequencer traffic while busy.
module ram_sorter #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               busy,
    output logic               done,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic               host_we,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic               cnt_hi_sel,
    output logic [CNT_W/2-1:0] cycle_half
);
    logic [ADDR_W-1:0] ctl_addr;
    logic              ctl_we;
    logic [DATA_W-1:0] ctl_wdata;
    logic              accept;
    logic [ADDR_W-1:0] ram_addr;
    logic              ram_we;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] ram_rdata;
    logic [CNT_W-1:0]  cycles_full;

    // Hand the memory to the sequencer while busy.
    always_comb begin
        ram_addr   = busy ? ctl_addr  : host_addr;
        ram_we     = busy ? ctl_we    : host_we;
        ram_wdata  = busy ? ctl_wdata : host_wdata;
        host_rdata = ram_rdata;
    end

    sort_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (ram_addr),
        .we    (ram_we),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    sort_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .rdata  (ram_rdata),
        .addr   (ctl_addr),
        .we     (ctl_we),
        .wdata  (ctl_wdata),
        .busy   (busy),
        .done   (done),
        .accept (accept)
    );

    sort_cycle_meter #(.CNT_W(CNT_W)) i_meter (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .inc    (busy),
        .hi_sel (cnt_hi_sel),
        .count  (cycles_full),
        .half   (cycle_half)
    );
endmodule

// File: rtl/ram_sorter_checker.sv
// Module: protocol and counter properties for ram_sorter, bound to it.
// Assumes: a count of 2^CNT_W busy cycles is never reached.
module ram_sorter_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] cnt
);
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R5
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done); // R5
    AST_IDLE_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> busy && !done && (cnt == '0)); // R2
    AST_BUSY_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> cnt == $past(cnt) + 1'b1); // R9
    AST_BUSY_START_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> cnt != '0); // R6
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(cnt)); // R9
endmodule

bind ram_sorter ram_sorter_checker #(.CNT_W(CNT_W)) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .cnt   (cycles_full)
);

// File: tb/test_ram_sorter.sv
// Bench: table-driven sorts with model cycle totals, then directed cases.
module test_ram_sorter;
    localparam int AW = 5;
    localparam int N  = 1 << AW;
    localparam int NV = 6;
    // Upper byte: pattern kind; lower byte: seed.
    // Kinds: 0 pseudo-random, 1 ascending, 2 descending, 3 constant, 4 alternating 7F/80.
    localparam logic [15:0] VEC [NV] = '{16'h0013, 16'h0101, 16'h0200, 16'h03A7, 16'h0400, 16'h00C4};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             busy, done;
    logic [AW-1:0]    host_addr = '0;
    logic             host_we = 1'b0;
    logic [7:0]       host_wdata = '0;
    logic [7:0]       host_rdata;
    logic             cnt_hi_sel = 1'b0;
    logic [15:0]      cycle_half;

    int nchk = 0;
    int nfail = 0;
    int wd = 0;
    logic [7:0] src [N];
    logic [7:0] mdl [N];
    logic [7:0] got [N];
    int exp_cyc;

    always #4 clk = ~clk;

    ram_sorter #(.ADDR_W(AW), .DATA_W(8), .CNT_W(32)) i_ram_sorter (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .host_addr(host_addr), .host_we(host_we), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .cnt_hi_sel(cnt_hi_sel), .cycle_half(cycle_half)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=<150000", wd);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic host_write(input int a, input logic [7:0] d);
        host_addr  = AW'(a);
        host_wdata = d;
        host_we    = 1'b1;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic load_src();
        for (int i = 0; i < N; i++) host_write(i, src[i]);
    endtask

    task automatic read_all();
        for (int i = 0; i < N; i++) begin
            host_addr = AW'(i);
            @(negedge clk);
            got[i] = host_rdata;
        end
    endtask

    // Model of the pass schedule and cost from R9.
    task automatic model();
        int lim;
        bit sw;
        logic [7:0] t;
        for (int i = 0; i < N; i++) mdl[i] = src[i];
        exp_cyc = 0;
        lim = N - 2;
        forever begin
            sw = 1'b0;
            for (int i = 0; i <= lim; i++) begin
                exp_cyc += 3;
                if (mdl[i] < mdl[i+1]) begin
                    t = mdl[i]; mdl[i] = mdl[i+1]; mdl[i+1] = t;
                    exp_cyc += 2;
                    sw = 1'b1;
                end
            end
            if (!sw || lim == 0) break;
            lim--;
        end
    endtask

    task automatic fill(input logic [15:0] v);
        logic [7:0] x;
        x = v[7:0];
        for (int i = 0; i < N; i++) begin
            case (v[15:8])
                8'd0: begin x = x * 8'd37 + 8'd11; src[i] = x; end
                8'd1: src[i] = 8'(i * 7);
                8'd2: src[i] = 8'(250 - i * 5);
                8'd3: src[i] = v[7:0];
                default: src[i] = (i % 2 == 0) ? 8'h7F : 8'h80;
            endcase
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    // Check order, contents and cycle total against the model.
    task automatic check_result(input string tag);
        bit ord_ok, perm_ok;
        int bad;
        read_all();
        ord_ok = 1'b1; bad = 0;
        for (int i = 0; i < N - 1; i++) if (got[i] < got[i+1]) begin ord_ok = 1'b0; bad = i; end
        chk(ord_ok, {"R3 R12 order ", tag}, {got[bad], got[bad+1]}, 32'h0);
        perm_ok = 1'b1; bad = 0;
        for (int i = 0; i < N; i++) if (got[i] !== mdl[i]) begin perm_ok = 1'b0; bad = i; end
        chk(perm_ok, {"R4 contents ", tag}, got[bad], mdl[bad]);
        cnt_hi_sel = 1'b0; #1;
        chk(cycle_half == exp_cyc[15:0], {"R9 R10 count low ", tag}, cycle_half, exp_cyc[15:0]);
        cnt_hi_sel = 1'b1; #1;
        chk(cycle_half == exp_cyc[31:16], {"R10 count high ", tag}, cycle_half, exp_cyc[31:16]);
        cnt_hi_sel = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R1 flags after reset", {busy, done}, 0);
        chk(cycle_half == 16'h0, "R1 count after reset", cycle_half, 0);

        // R7: host write then read with one-cycle latency.
        host_write(3, 8'h5A);
        host_addr = AW'(3);
        @(negedge clk);
        chk(host_rdata == 8'h5A, "R7 host readback", host_rdata, 8'h5A);

        for (int v = 0; v < NV; v++) begin
            fill(VEC[v]);
            model();
            load_src();
            pulse_start();
            chk(busy && !done && cycle_half == 16'h0, "R2 start accepted", {busy, done, cycle_half}, 18'h20000);
            wait_done();
            check_result($sformatf("vec%0d", v));
        end

        // R11: already non-increasing input takes one pass.
        fill(16'h0200);
        model();
        load_src();
        pulse_start();
        wait_done();
        cnt_hi_sel = 1'b0; #1;
        chk(cycle_half == 16'(3 * (N - 1)), "R11 sorted input one pass", cycle_half, 3 * (N - 1));

        // R5: done holds and count frozen while idle.
        repeat (10) @(negedge clk);
        chk(done && !busy && cycle_half == 16'(3 * (N - 1)), "R5 done held, count frozen", {done, busy, cycle_half}, 18'h20000 | (3 * (N - 1)));

        // R6 and R8: start and host write during a sort are ignored.
        fill(16'h0077);
        model();
        load_src();
        pulse_start();
        repeat (4) @(negedge clk);
        start = 1'b1; host_we = 1'b1; host_addr = '0; host_wdata = 8'hFF;
        @(negedge clk);
        start = 1'b0; host_we = 1'b0;
        host_addr = AW'(N - 1); host_wdata = 8'hFE; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
        chk(busy, "R6 still busy after extra start", busy, 1);
        wait_done();
        check_result("R6 R8 busy stimulus");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule